// File: doc/BRIEF.md
# Sliding-Window DCT/DST Lattice Array

This block keeps a running N-point cosine transform and sine transform of the most recent N samples of a continuous stream. Each accepted sample moves the window forward by one position. Every coefficient is then updated from its own previous value, the incoming sample and the sample that drops out of the window. Nothing is recomputed in blocks and nothing is transposed. One sample can be accepted in every clock cycle, and all 2N coefficients change in the same cycle.

The array is a row of identical cells, one for each index k. A cell holds the pair (C_k, S_k) as a single rotating state. On each accepted sample the cell rotates the pair by the angle pi*k/N and adds one input term. For even k that term is the new sample minus the departing sample. For odd k it is the new sample plus the departing sample. This makes the window edge cancel exactly. An N-deep shift register supplies the departing sample, and both input terms are broadcast to every cell.

A small controller has two states. FILL is entered at reset. The transition FILL->RUN is taken when the N-th sample after reset is accepted. RUN holds until the next reset, and in RUN the valid flag is high. Rotation constants are fixed at elaboration. Products are rounded to nearest, and state words carry guard bits and saturate symmetrically.

Top module: `dct_dst_lattice`

## Requirements
- R1: While reset is asserted and after it is released, `out_vld` is 0 and every DCT and DST output is 0 until a sample is accepted.
- R2: `out_vld` rises on the clock edge that accepts the N-th sample (`in_vld`=1) after reset and then stays 1. Cycles with `in_vld`=0 are not counted.
- R3: After each accepted sample, DCT output k (bits [k*OW +: OW] of `dct_out`, signed) equals sum over i=0..N-1 of x[n-i]*cos(pi*k*i/N), rounded, within 3 LSB. Here x[n] is the newest sample, and samples from before reset count as 0.
- R4: After each accepted sample, DST output k (bits [k*OW +: OW] of `dst_out`, signed) equals sum over i=0..N-1 of x[n-i]*sin(pi*k*i/N), within 3 LSB.
- R5: DST output 0 is exactly 0 at all times.
- R6: In a cycle with `in_vld`=0 no output and no flag changes, whatever the value on `in_smp`.
- R7: The outputs reflect an accepted sample from the clock edge that accepts it, so back-to-back samples are each reflected one cycle apart.
- R8: Full-scale input of either sign for a whole window gives DCT output 0 equal to N times the sample within tolerance, with no wrap. State never takes the most negative code.
- R9: A sample has no influence once N newer samples have been accepted. After an impulse followed by N zeros, all outputs return to 0 within tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample strobe; one sample accepted per cycle when high |
| in_smp | input | IN_W | Signed two's-complement input sample |
| out_vld | output | 1 | High once the window holds N accepted samples |
| dct_out | output | N*OW | N signed cosine coefficients, index k at [k*OW +: OW], OW = IN_W+clog2(N)+2 |
| dst_out | output | N*OW | N signed sine coefficients, same packing |

## Verification
Each cell's state feeds back into itself through a rotation that neither grows nor decays. A wrong value in any cell therefore never fades out. It reappears, rotated, on that cell's outputs on the very next accepted sample and on every later one. A wrong departing sample from the delay line shows up N accepts later, as outputs that fail to return to zero after an impulse. A controller fault shows up as `out_vld` rising one sample early or late, or rising during cycles with no strobe.

// File: rtl/dct_lat_pkg.sv
package dct_lat_pkg;

    typedef enum logic [0:0] {
        S_FILL = 1'b0,
        S_RUN  = 1'b1
    } lat_state_e;

    localparam real LAT_PI = 3.14159265358979323846;

    // Quantise cos or sin of an angle in [0, pi) to a fixed-point integer
    // with 'frac' fractional bits, round half away from zero.
    function automatic longint q_trig(input real ang, input bit want_sin, input int frac);
        real a2;
        real term;
        real sum;
        real scale;
        a2 = ang * ang;
        if (want_sin) begin
            term = ang;
            sum  = ang;
            for (int n = 1; n < 24; n++) begin
                term = -term * a2 / ((2.0 * n) * (2.0 * n + 1.0));
                sum  = sum + term;
            end
        end else begin
            term = 1.0;
            sum  = 1.0;
            for (int n = 1; n < 24; n++) begin
                term = -term * a2 / ((2.0 * n - 1.0) * (2.0 * n));
                sum  = sum + term;
            end
        end
        scale = 1.0;
        for (int b = 0; b < frac; b++) scale = scale * 2.0;
        if (sum >= 0.0) q_trig = longint'($rtoi(sum * scale + 0.5));
        else            q_trig = -longint'($rtoi(-sum * scale + 0.5));
    endfunction

endpackage

// File: rtl/lat_ctrl.sv
module lat_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    output logic out_vld
);
    import dct_lat_pkg::*;

    localparam int CNT_W = $clog2(N) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

    lat_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            S_FILL: begin
                if (in_vld) begin
                    if (cnt_q == LAST) begin
                        st_d  = S_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_RUN: begin
                st_d = S_RUN;
            end
            default: st_d = S_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_FILL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        out_vld = (st_q == S_RUN);
    end

    // R2: the fill counter never passes the last window slot
    assert_fill_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2: valid only rises on an edge that accepted a sample
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(in_vld));

    // R6: valid never falls once set
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> out_vld);

endmodule

// File: rtl/lat_delay.sv
module lat_delay #(
    parameter int N    = 8,
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_smp,
    output logic signed [IN_W:0]   u_even,
    output logic signed [IN_W:0]   u_odd
);
    logic signed [IN_W-1:0] taps [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) taps[i] <= '0;
        end else if (in_vld) begin
            taps[0] <= in_smp;
            for (int i = 1; i < N; i++) taps[i] <= taps[i-1];
        end
    end

    // taps[N-1] is the sample that leaves the window on this accept
    always_comb begin
        u_even = (IN_W+1)'(in_smp) - (IN_W+1)'(taps[N-1]);
        u_odd  = (IN_W+1)'(in_smp) + (IN_W+1)'(taps[N-1]);
    end

    // R9: the newest tap is the sample just accepted
    assert_tap_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> taps[0] == $past(in_smp));

    // R6: the delay line holds without a strobe
    assert_tap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> taps[N-1] == $past(taps[N-1]));

endmodule

// File: rtl/lat_cell.sv
module lat_cell #(
    parameter int N    = 8,
    parameter int K    = 1,
    parameter int IN_W = 12,
    parameter int SW   = 25,
    parameter int F    = 8,
    parameter int CW   = 24,
    parameter int OW   = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [IN_W:0] u_even,
    input  logic signed [IN_W:0] u_odd,
    output logic signed [OW-1:0] c_out,
    output logic signed [OW-1:0] s_out
);
    localparam int UW = IN_W + 1;
    localparam int AW = SW + 2;
    localparam int RW = SW + 1;
    localparam logic signed [AW-1:0] SAT_HI = $signed({{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}});
    localparam logic signed [AW-1:0] SAT_LO = -SAT_HI;
    localparam logic signed [SW-1:0] MIN_CODE = $signed({1'b1, {(SW-1){1'b0}}});
    localparam logic signed [RW-1:0] OUT_HI = $signed({{(RW-OW+1){1'b0}}, {(OW-1){1'b1}}});
    localparam logic signed [RW-1:0] HALF_F = RW'(1) <<< (F - 1);

    logic signed [SW-1:0] c_q, s_q;
    logic signed [AW-1:0] c_nx, s_nx;
    logic signed [UW-1:0] u;
    logic signed [AW-1:0] u_sc;

    always_comb begin
        u    = ((K % 2) == 0) ? u_even : u_odd;
        u_sc = AW'(u) <<< F;
    end

    generate
        if (K == 0) begin : g_dc
            // rotation by zero: plain accumulator, sine part stays zero
            always_comb begin
                c_nx = AW'(c_q) + u_sc;
                s_nx = '0;
            end
        end else begin : g_rot
            localparam int CF = CW - 2;
            localparam int PW = SW + CW + 1;
            localparam real ANG = dct_lat_pkg::LAT_PI * K / N;
            localparam longint CQ = dct_lat_pkg::q_trig(ANG, 1'b0, CF);
            localparam longint SQ = dct_lat_pkg::q_trig(ANG, 1'b1, CF);
            localparam logic signed [CW-1:0] COS_Q = CW'(CQ);
            localparam logic signed [CW-1:0] SIN_Q = CW'(SQ);
            localparam logic signed [PW-1:0] HALF_C = PW'(1) <<< (CF - 1);

            logic signed [PW-1:0] pc, ps;
            always_comb begin
                pc = PW'(c_q) * PW'(COS_Q) - PW'(s_q) * PW'(SIN_Q);
                ps = PW'(c_q) * PW'(SIN_Q) + PW'(s_q) * PW'(COS_Q);
                c_nx = AW'((pc + HALF_C) >>> CF) + u_sc;
                s_nx = AW'((ps + HALF_C) >>> CF);
            end
        end
    endgenerate

    function automatic logic signed [SW-1:0] clamp(input logic signed [AW-1:0] v);
        if (v > SAT_HI)      clamp = SW'(SAT_HI);
        else if (v < SAT_LO) clamp = SW'(SAT_LO);
        else                 clamp = SW'(v);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            s_q <= '0;
        end else if (en) begin
            c_q <= clamp(c_nx);
            s_q <= clamp(s_nx);
        end
    end

    function automatic logic signed [OW-1:0] to_out(input logic signed [SW-1:0] v);
        logic signed [RW-1:0] r;
        r = (RW'(v) + HALF_F) >>> F;
        if (r > OUT_HI) to_out = OW'(OUT_HI);
        else            to_out = OW'(r);
    endfunction

    always_comb begin
        c_out = to_out(c_q);
        s_out = to_out(s_q);
    end

    // R8: saturation keeps the state off the most negative code
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q != MIN_CODE) && (s_q != MIN_CODE));

    // R6: state frozen while no sample is accepted
    assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(c_q) && $stable(s_q));

    // R5: index zero carries no sine content
    if (K == 0) begin : g_chk_dc
        assert_dc_sine_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            s_out == '0);
    end

endmodule

// File: rtl/dct_dst_lattice.sv
module dct_dst_lattice #(
    parameter int N    = 8,
    parameter int IN_W = 12,
    parameter int F    = 8,
    parameter int CW   = 24,
    parameter int OW   = IN_W + $clog2(N) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [IN_W-1:0]      in_smp,
    output logic                 out_vld,
    output logic [N*OW-1:0]      dct_out,
    output logic [N*OW-1:0]      dst_out
);
    localparam int SW = OW + F;

    logic signed [IN_W:0] u_even, u_odd;

    lat_ctrl #(.N(N)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .out_vld(out_vld)
    );

    lat_delay #(.N(N), .IN_W(IN_W)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (in_vld),
        .in_smp ($signed(in_smp)),
        .u_even (u_even),
        .u_odd  (u_odd)
    );

    for (genvar k = 0; k < N; k++) begin : g_cell
        logic signed [OW-1:0] c_k, s_k;
        lat_cell #(
            .N(N), .K(k), .IN_W(IN_W), .SW(SW), .F(F), .CW(CW), .OW(OW)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_vld),
            .u_even(u_even),
            .u_odd (u_odd),
            .c_out (c_k),
            .s_out (s_k)
        );
        assign dct_out[k*OW +: OW] = c_k;
        assign dst_out[k*OW +: OW] = s_k;
    end

    // R1: outputs idle after reset until the first strobe
    assert_valid_needs_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_vld && !$past(in_vld) && $past(dct_out) == '0) |-> dct_out == '0);

endmodule

// File: tb/dct_dst_lattice_bench.sv
module dct_dst_lattice_bench;
    localparam int N      = 8;
    localparam int IN_W   = 12;
    localparam int OW     = IN_W + $clog2(N) + 2;
    localparam int TOL    = 3;
    localparam time PERIOD = 10ns;
    localparam real PI    = 3.14159265358979323846;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [IN_W-1:0]   in_smp = '0;
    logic              out_vld;
    logic [N*OW-1:0]   dct_out;
    logic [N*OW-1:0]   dst_out;

    int checks = 0;
    int errors = 0;
    int hist [N];
    int nacc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(PERIOD/2) clk = ~clk;

    dct_dst_lattice #(.N(N), .IN_W(IN_W)) u_dct_dst_lattice (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp),
        .out_vld(out_vld), .dct_out(dct_out), .dst_out(dst_out)
    );

    function automatic int got_c(input int k);
        got_c = int'($signed(dct_out[k*OW +: OW]));
    endfunction
    function automatic int got_s(input int k);
        got_s = int'($signed(dst_out[k*OW +: OW]));
    endfunction

    function automatic int ref_val(input int k, input bit sine);
        real acc = 0.0;
        for (int i = 0; i < N; i++) begin
            if (sine) acc += hist[i] * $sin(PI * k * i / N);
            else      acc += hist[i] * $cos(PI * k * i / N);
        end
        ref_val = (acc >= 0.0) ? $rtoi(acc + 0.5) : -$rtoi(-acc + 0.5);
    endfunction

    task automatic check_int(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (tol %0d) at %0t", req, act, exp, tol, $time);
        end
    endtask

    // R3, R4, R5: all coefficients against a direct window transform
    task automatic check_all();
        for (int k = 0; k < N; k++) begin
            check_int("R3", got_c(k), ref_val(k, 1'b0), TOL);
            check_int("R4", got_s(k), ref_val(k, 1'b1), TOL);
        end
        check_int("R5", got_s(0), 0, 0);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_smp = '0;
        for (int i = 0; i < N; i++) hist[i] = 0;
        nacc = 0;
        repeat (3) @(negedge clk);
        check_int("R1", int'(out_vld), 0, 0);
        check_int("R1", int'(dct_out != '0 || dst_out != '0), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1", int'(out_vld), 0, 0);
        check_int("R1", int'(dct_out != '0 || dst_out != '0), 0, 0);
    endtask

    // drive at a falling edge, sample at the next falling edge (R7)
    task automatic step(input int x, input bit v);
        in_smp = IN_W'(x);
        in_vld = v;
        @(negedge clk);
        if (v) begin
            for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
            nacc++;
        end
        check_all();
        check_int("R2", int'(out_vld), int'(nacc >= N), 0);
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        next_rand = int'($signed(lfsr[IN_W-1:0]));
    endfunction

    task automatic t_fill_gaps();
        do_reset();
        for (int i = 0; i < N; i++) begin
            step(100 * (i + 1) - 350, 1'b1);
            step(1500, 1'b0);
        end
        check_int("R2", int'(out_vld), 1, 0);
    endtask

    task automatic t_hold();
        logic [N*OW-1:0] c_save, s_save;
        do_reset();
        for (int i = 0; i < N + 3; i++) step(next_rand(), 1'b1);
        c_save = dct_out;
        s_save = dst_out;
        for (int i = 0; i < 5; i++) begin
            step(next_rand(), 1'b0);
            check_int("R6", int'(dct_out == c_save && dst_out == s_save), 1, 0);
            check_int("R6", int'(out_vld), 1, 0);
        end
    endtask

    task automatic t_ramp();
        do_reset();
        for (int i = 0; i < 60; i++) step((i * 37) % 1800 - 900, 1'b1);
    endtask

    task automatic t_alternate();
        do_reset();
        for (int i = 0; i < 40; i++) step((i % 2 == 0) ? 1200 : -1200, 1'b1);
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 150; i++) step(next_rand(), 1'b1);
    endtask

    task automatic t_full_scale();
        do_reset();
        for (int i = 0; i < N + 4; i++) step(2047, 1'b1);
        check_int("R8", got_c(0), N * 2047, TOL);
        for (int i = 0; i < N + 4; i++) step(-2048, 1'b1);
        check_int("R8", got_c(0), -N * 2048, TOL);
    endtask

    task automatic t_impulse();
        do_reset();
        for (int i = 0; i < 10; i++) step(next_rand(), 1'b1);
        step(2000, 1'b1);
        for (int i = 0; i < N; i++) step(0, 1'b1);
        for (int k = 0; k < N; k++) begin
            check_int("R9", got_c(k), 0, TOL);
            check_int("R9", got_s(k), 0, TOL);
        end
    endtask

    bit done = 1'b0;

    initial begin
        t_fill_gaps();
        t_hold();
        t_ramp();
        t_alternate();
        t_random();
        t_full_scale();
        t_impulse();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule